// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Divider

This block divides a fast input clock by a programmable integer ratio, as the feedback divider of a frequency synthesizer. It is built from three parts. The first is a dual-modulus prescaler whose modulus is 32 or 33. The second is a 5-bit swallow count A. The third is a 10-bit main count B.

In each output period the prescaler runs at modulus 33 for A of its periods and at modulus 32 for the remaining B−A periods. One output period is therefore 32·B + A input clocks. The modulus select is brought out as a port, so it can be observed as it would be on a separate prescaler.

Software presents new A and B values with a one-cycle load strobe. The values are held in a shadow stage. Both counts reload from that stage at each output boundary, so the period already in progress keeps the ratio it started with. Legal settings are B from 3 to 1023 and A from 0 to 31 with A ≤ B. These cover every ratio from 992 to 32767 and the smaller ratios that meet A ≤ B.

Top module: `pswallow_div`

## Requirements
- R1: While rst_ni is low, pulse_o and modsel_o are 0. After release the default ratio is A=0, B=3, and the first pulse_o is high in the 96th input-clock cycle after release.
- R2: For any legal A and B in effect, consecutive pulse_o assertions are exactly 32·B + A input clocks apart.
- R3: pulse_o is high for exactly one input clock per output period.
- R4: Within each output period, modsel_o (1 = divide by 33, 0 = divide by 32) is high for exactly 33·A input clocks. These clocks start with the first clock of the period, and modsel_o rises only on the clock right after a pulse_o.
- R5: With A = 0, modsel_o stays 0 for the whole output period.
- R6: A load_i pulse that does not coincide with pulse_o leaves the length of the current period unchanged. The new values govern the period that starts after the next pulse_o.
- R7: A load_i pulse in the same cycle as pulse_o takes effect for the period that starts on the next clock.
- R8: The extreme legal settings divide correctly: B=3 with A=0 (96), A=B (for example 99 and 1023), and B=1023 with A=31 (32767).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that captures a_i and b_i |
| a_i | input | 5 | Swallow count A (0..31, not above B) |
| b_i | input | 10 | Main count B (3..1023) |
| pulse_o | output | 1 | One-clock pulse, one per output period |
| modsel_o | output | 1 | Prescaler modulus select, 1 = divide by 33 |

## Verification
A wrong main count or a missed reload moves the next pulse_o. The error shows in the first output period that uses the affected value, as a spacing different from 32·B + A. A corrupted swallow count, or a prescaler that uses the wrong modulus, changes the number of modsel_o-high clocks in that same period. The period length also shifts by a multiple of one clock. A load taken at the wrong moment shows as a period of the new length one boundary too early or too late, so the bench measures the period that contains the load as well as the one after it.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int PRE_W  = 5;   // prescaler base modulus = 2**PRE_W
  localparam int SWAL_W = 5;
  localparam int MAIN_W = 10;

  typedef enum logic {
    MOD_BASE = 1'b0,   // divide by P
    MOD_PLUS = 1'b1    // divide by P+1
  } mod_e;
endpackage

// File: rtl/pswallow_shadow.sv
module pswallow_shadow #(
  parameter int SWAL_W = 5,
  parameter int MAIN_W = 10,
  parameter logic [SWAL_W-1:0] RST_A = '0,
  parameter logic [MAIN_W-1:0] RST_B = MAIN_W'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SWAL_W-1:0] a_i,
  input  logic [MAIN_W-1:0] b_i,
  output logic [SWAL_W-1:0] a_ld_o,
  output logic [MAIN_W-1:0] b_ld_o
);
  logic [SWAL_W-1:0] a_q;
  logic [MAIN_W-1:0] b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= RST_A;
      b_q <= RST_B;
    end else if (load_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // bypass so a load on the boundary cycle is not lost for a period
  assign a_ld_o = load_i ? a_i : a_q;
  assign b_ld_o = load_i ? b_i : b_q;
endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mod_e         mod_i,
  output logic         tick_o,
  output logic [PRE_W:0] cnt_o
);
  localparam logic [PRE_W:0] LAST_BASE = {1'b0, {PRE_W{1'b1}}};  // P-1
  localparam logic [PRE_W:0] LAST_PLUS = {1'b1, {PRE_W{1'b0}}};  // P

  logic [PRE_W:0] cnt_q;
  logic [PRE_W:0] last;

  assign last   = (mod_i == MOD_PLUS) ? LAST_PLUS : LAST_BASE;
  assign tick_o = (cnt_q == last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pswallow_swallow_cnt.sv
module pswallow_swallow_cnt
  import pswallow_pkg::*;
#(
  parameter int SWAL_W = 5,
  parameter logic [SWAL_W-1:0] RST_A = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reload_i,
  input  logic [SWAL_W-1:0] a_ld_i,
  output mod_e              mod_o
);
  logic [SWAL_W-1:0] a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    a_q <= RST_A;
    else if (reload_i)              a_q <= a_ld_i;
    else if (tick_i && a_q != '0)   a_q <= a_q - 1'b1;
  end

  assign mod_o = (a_q != '0) ? MOD_PLUS : MOD_BASE;
endmodule

// File: rtl/pswallow_main_cnt.sv
module pswallow_main_cnt #(
  parameter int MAIN_W = 10,
  parameter logic [MAIN_W-1:0] RST_B = MAIN_W'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [MAIN_W-1:0] b_ld_i,
  output logic              term_o,
  output logic [MAIN_W-1:0] cnt_o
);
  logic [MAIN_W-1:0] b_q;

  // terminal: last prescaler period of the output cycle completes
  assign term_o = tick_i && (b_q == MAIN_W'(1));
  assign cnt_o  = b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     b_q <= RST_B;
    else if (term_o) b_q <= b_ld_i;
    else if (tick_i) b_q <= b_q - 1'b1;
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int PRE_W  = pswallow_pkg::PRE_W,
  parameter int SWAL_W = pswallow_pkg::SWAL_W,
  parameter int MAIN_W = pswallow_pkg::MAIN_W,
  parameter logic [SWAL_W-1:0] RST_A = '0,
  parameter logic [MAIN_W-1:0] RST_B = MAIN_W'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SWAL_W-1:0] a_i,
  input  logic [MAIN_W-1:0] b_i,
  output logic              pulse_o,
  output logic              modsel_o
);
  logic [SWAL_W-1:0] a_ld;
  logic [MAIN_W-1:0] b_ld;
  logic              pre_tick;
  logic [PRE_W:0]    pre_cnt;
  logic [MAIN_W-1:0] main_cnt;
  logic              boundary;
  mod_e              mod_sel;

  pswallow_shadow #(
    .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .RST_A(RST_A), .RST_B(RST_B)
  ) u_shadow (
    .clk_i, .rst_ni, .load_i, .a_i, .b_i,
    .a_ld_o(a_ld), .b_ld_o(b_ld)
  );

  pswallow_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .mod_i(mod_sel), .tick_o(pre_tick), .cnt_o(pre_cnt)
  );

  pswallow_swallow_cnt #(.SWAL_W(SWAL_W), .RST_A(RST_A)) u_swal (
    .clk_i, .rst_ni, .tick_i(pre_tick), .reload_i(boundary),
    .a_ld_i(a_ld), .mod_o(mod_sel)
  );

  pswallow_main_cnt #(.MAIN_W(MAIN_W), .RST_B(RST_B)) u_main (
    .clk_i, .rst_ni, .tick_i(pre_tick), .b_ld_i(b_ld),
    .term_o(boundary), .cnt_o(main_cnt)
  );

  assign pulse_o  = boundary;
  assign modsel_o = (mod_sel == MOD_PLUS);
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int PRE_W  = 5,
  parameter int MAIN_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_o,
  input logic              modsel_o,
  input logic              pre_tick,
  input logic [PRE_W:0]    pre_cnt,
  input logic [MAIN_W-1:0] main_cnt
);
  localparam logic [PRE_W:0] P_VAL = {1'b1, {PRE_W{1'b0}}};

  // R3
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R4
  modsel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modsel_o) |-> $past(pulse_o));

  // R4
  modsel_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(modsel_o) |-> $past(pre_tick));

  // R2
  base_modulus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !modsel_o |-> (pre_cnt < P_VAL));

  // R2
  main_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_tick |=> $stable(main_cnt));
endmodule

bind pswallow_div pswallow_div_chk #(.PRE_W(PRE_W), .MAIN_W(MAIN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pulse_o(pulse_o), .modsel_o(modsel_o),
  .pre_tick(pre_tick), .pre_cnt(pre_cnt), .main_cnt(main_cnt)
);

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps
module pswallow_div_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [4:0] a_i = '0;
  logic [9:0] b_i = '0;
  logic       pulse_o, modsel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int cur_a, cur_b;

  always #2.5 clk_i = ~clk_i;

  pswallow_div u_pswallow_div (
    .clk_i, .rst_ni, .load_i, .a_i, .b_i, .pulse_o, .modsel_o
  );

  function automatic int exp_len(int a, int b);
    return 32 * b + a;
  endfunction

  function automatic int exp_mod(int a);
    return 33 * a;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  // Called at a negedge where pulse_o is high. Loads (na, nb) k clocks into
  // the next period (k = 0: same cycle as the pulse) and measures that period.
  task automatic step(int na, int nb, int k);
    int len = 0;
    int mh  = 0;
    int ea, eb;
    if (k == 0) begin
      a_i = 5'(na); b_i = 10'(nb); load_i = 1'b1;
      cur_a = na; cur_b = nb;
    end
    ea = cur_a; eb = cur_b;
    do begin
      @(negedge clk_i);
      load_i = 1'b0;
      len++;
      if (modsel_o) mh++;
      if (k != 0 && len == k) begin
        a_i = 5'(na); b_i = 10'(nb); load_i = 1'b1;
      end
    end while (!pulse_o && len < 40000);
    load_i = 1'b0;
    // R2 spacing; R6 when k != 0 (old values still apply); R7 when k == 0
    check(k == 0 ? "R7/R2 period" : "R6/R2 period", len, exp_len(ea, eb));
    // R4 modulus-select dwell; R5 when A == 0
    check(ea == 0 ? "R5 modsel" : "R4 modsel", mh, exp_mod(ea));
    if (k != 0) begin
      cur_a = na; cur_b = nb;
    end
  endtask

  initial begin
    int cnt, seed, rb, ra, lim;
    int one_wide;
    seed = $urandom(32'd5150);
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 pulse in reset", int'(pulse_o), 0);
    check("R1 modsel in reset", int'(modsel_o), 0);
    rst_ni = 1'b1;
    cnt = 0;
    while (!pulse_o && cnt < 1000) begin
      @(negedge clk_i);
      cnt++;
    end
    check("R1 first pulse", cnt + 1, 96);
    // R3 pulse lasts one clock
    @(negedge clk_i);
    one_wide = int'(pulse_o);
    check("R3 width", one_wide, 0);
    cnt = 1;
    while (!pulse_o && cnt < 1000) begin
      @(negedge clk_i);
      cnt++;
    end
    cur_a = 0; cur_b = 3;
    // R8 default minimum 96, measured from a pulse
    step(0, 3, 5);
    // R8 directed corners
    step(3, 3, 0);        // A = B = 3 -> 99
    step(0, 3, 7);
    step(31, 31, 10);
    step(31, 1023, 0);    // 32767
    step(0, 1023, 50);    // R8 A = 0 with max B
    step(17, 40, 20);
    step(5, 5, 12);
    // constrained random
    for (int i = 0; i < 24; i++) begin
      rb  = 3 + int'($urandom % 60);
      lim = (rb < 31) ? rb : 31;
      ra  = int'($urandom % (lim + 1));
      step(ra, rb, ((i % 5) == 0) ? 0 : 1 + int'($urandom % 40));
    end
    step(0, 3, 3);
    step(0, 3, 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule